// File: doc/BRIEF.md
# Two-Wire Configuration Register Loader

This block loads a control word into a receiver's configuration register over two wires: a clock line driven by an external master, and a data line the receiver normally drives with its demodulated output. While the clock line is high and no transfer is under way, the block releases the data pad so the master can pull it low. A transfer opens with a framing pattern made of data edges while the clock is high. Bits follow, most significant first. A second framing pattern closes the transfer and writes the received bits into the register.

The last bit of every write lands in bit 0. A short write therefore changes only the lowest bits, and every higher bit keeps its value. Both input lines pass through a synchroniser before edge detection, so the block runs on its own system clock. The register is reloaded with its default value on reset.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the register holds 20'h02E78, which sets bits 3, 4, 5, 6, 9, 10, 11 and 13 and clears every other bit. With the clock line low, the pad output enable is 1.
- R2: Outside a transfer, the output enable is 0 while the clock line is high and 1 while it is low. A clock rise with the data line high opens no transfer.
- R3: A transfer opens only after this sequence: a clock rise while data is low, then a data rise, then a data fall, all with the clock still high. From then until the transfer closes, the output enable stays 0, even while the clock line is low.
- R4: Inside a transfer, the data level is sampled at each clock rise. A bit is accepted at the following clock fall if the data did not change while the clock was high. Bits shift in most significant first, and the last accepted bit ends in bit 0.
- R5: A write of N accepted bits, with N from 1 to 20, updates bits N-1 down to 0. The bits above stay unchanged.
- R6: A transfer closes when the following happens with the clock high: data rises, then data falls, then the clock falls. The write is committed at that clock fall, and the output enable returns to 1 while the clock stays low.
- R7: A transfer that closes with no accepted bits leaves the register unchanged.
- R8: When more than 20 bits are accepted, the register takes the last 20.
- R9: The register changes only when a transfer closes. If the clock falls before the opening sequence completes, no transfer opens, the register keeps its value, and the output enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Clock line from the external master (asynchronous) |
| ser_dat_i | input | 1 | Level seen on the shared data pad (asynchronous) |
| cfg_o | output | 20 | Configuration register contents |
| dat_oe_o | output | 1 | Output enable for the shared data pad; 1 lets the receiver drive it |

## Verification
The bench builds the block with its default parameters: a 20-bit register, two synchroniser stages and the default reset word. With these values, writes of length 0, 20 and more than 20 are all reachable, so both ends of the write mask and the saturating bit counter get exercised. Each line phase is held for six system clocks. That is well beyond the three-cycle synchroniser and edge-detect latency, so every framing edge is seen as a separate event. Random write lengths from 0 to 25 bits, with random contents, are checked against a bench model of the masked update. Directed cases add an aborted opening sequence and idle clocking.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ARM  = 3'd1,
      ST_PRE  = 3'd2,
      ST_RECV = 3'd3,
      ST_STPH = 3'd4,
      ST_STPL = 3'd5
   } ld_state_t;

   localparam int unsigned DEF_REG_W = 20;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] lvl_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] chain_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cfgld_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cfgld_frame.sv
module cfgld_frame
   import cfgld_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clk_lvl_i,
   input  logic clk_rise_i,
   input  logic clk_fall_i,
   input  logic dat_lvl_i,
   input  logic dat_rise_i,
   input  logic dat_fall_i,
   output logic clear_o,
   output logic shift_o,
   output logic bit_o,
   output logic commit_o,
   output logic oe_o
);
   ld_state_t state_q, state_d;
   logic      pend_q, pend_vld_q, dirty_q;

   always_comb begin
      state_d  = state_q;
      clear_o  = 1'b0;
      shift_o  = 1'b0;
      commit_o = 1'b0;
      unique case (state_q)
         ST_IDLE: if (clk_rise_i && !dat_lvl_i) state_d = ST_ARM;
         ST_ARM: begin
            if (clk_fall_i)      state_d = ST_IDLE;
            else if (dat_rise_i) state_d = ST_PRE;
         end
         ST_PRE: begin
            if (clk_fall_i) state_d = ST_IDLE;
            else if (dat_fall_i) begin
               state_d = ST_RECV;
               clear_o = 1'b1;
            end
         end
         ST_RECV: begin
            if (dat_rise_i && clk_lvl_i) state_d = ST_STPH;
            else if (clk_fall_i && pend_vld_q && !dirty_q) shift_o = 1'b1;
         end
         ST_STPH: begin
            if (clk_fall_i)      state_d = ST_IDLE;
            else if (dat_fall_i) state_d = ST_STPL;
         end
         ST_STPL: begin
            if (clk_fall_i) begin
               state_d  = ST_IDLE;
               commit_o = 1'b1;
            end else if (dat_rise_i) state_d = ST_STPH;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pend_q     <= 1'b0;
         pend_vld_q <= 1'b0;
         dirty_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_RECV) begin
            pend_vld_q <= 1'b0;
            dirty_q    <= 1'b0;
         end else begin
            if (clk_rise_i) begin
               pend_q     <= dat_lvl_i;
               pend_vld_q <= 1'b1;
               dirty_q    <= 1'b0;
            end else if (clk_fall_i) begin
               pend_vld_q <= 1'b0;
            end
            if (dat_fall_i && clk_lvl_i) dirty_q <= 1'b1;
         end
      end
   end

   assign bit_o = pend_q;
   assign oe_o  = (state_q == ST_IDLE) && !clk_lvl_i;

   logic in_sess;
   assign in_sess = (state_q == ST_RECV) || (state_q == ST_STPH) || (state_q == ST_STPL);

   AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> (state_q == ST_IDLE)); // R6
   AST_SESSION_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sess) |-> clk_lvl_i); // R3
   AST_OE_OFF_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lvl_i |-> !oe_o); // R2
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
   parameter int unsigned      REG_W   = 20,
   parameter logic [REG_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             shift_i,
   input  logic             bit_i,
   input  logic             commit_i,
   output logic [REG_W-1:0] cfg_o
);
   localparam int unsigned CNT_W = $clog2(REG_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REG_W);

   logic [REG_W-1:0] shreg_q, cfg_q, upd;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (shift_i) begin
         shreg_q <= {shreg_q[REG_W-2:0], bit_i};
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < int'(REG_W); i++) begin : g_bit
         localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
         assign upd[i] = commit_i && (cnt_q > IDX);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[i] <= RST_VAL[i];
            else if (upd[i]) cfg_q[i] <= shreg_q[i];
         end
      end
   endgenerate

   assign cfg_o = cfg_q;

   AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> $past(commit_i)); // R9
   AST_EMPTY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && cnt_q == '0) |=> (cfg_q == $past(cfg_q))); // R7
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
   import cfgld_pkg::*;
#(
   parameter int unsigned      REG_W       = DEF_REG_W,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [REG_W-1:0] RST_VAL     = REG_W'(20'h02E78)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk_i,
   input  logic             ser_dat_i,
   output logic [REG_W-1:0] cfg_o,
   output logic             dat_oe_o
);
   generate
      if (REG_W < 2) begin : g_bad_w
         $error("serial_cfg_loader needs REG_W >= 2");
      end
   endgenerate

   logic [1:0] lvl, rise, fall;
   logic       clear, shift, sbit, commit;

   cfgld_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i({ser_dat_i, ser_clk_i}),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   cfgld_frame u_frame (
      .clk(clk), .rst_n(rst_n),
      .clk_lvl_i(lvl[0]), .clk_rise_i(rise[0]), .clk_fall_i(fall[0]),
      .dat_lvl_i(lvl[1]), .dat_rise_i(rise[1]), .dat_fall_i(fall[1]),
      .clear_o(clear), .shift_o(shift), .bit_o(sbit),
      .commit_o(commit), .oe_o(dat_oe_o)
   );

   cfgld_regs #(.REG_W(REG_W), .RST_VAL(RST_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .shift_i(shift),
      .bit_i(sbit), .commit_i(commit), .cfg_o(cfg_o)
   );
endmodule

// File: tb/serial_cfg_loader_bench.sv
module serial_cfg_loader_bench;
   localparam int H = 6;
   logic clk = 1'b0, rst_n = 1'b0, sc = 1'b0, sd = 1'b0;
   logic [19:0] cfg;
   logic        oe;
   int errors = 0, checks = 0;
   logic [19:0] exp_cfg;
   bit   done = 0;

   always #2 clk = ~clk;

   serial_cfg_loader u_serial_cfg_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sc), .ser_dat_i(sd),
      .cfg_o(cfg), .dat_oe_o(oe)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic c, logic d);
      @(negedge clk);
      sc = c; sd = d;
      repeat (H) @(posedge clk);
   endtask

   function automatic logic [19:0] model(logic [19:0] old, logic [31:0] seq, int n);
      logic [19:0] mask;
      if (n == 0) return old;
      mask = (n >= 20) ? 20'hFFFFF : 20'((32'd1 << n) - 1);
      return (old & ~mask) | (seq[19:0] & mask);
   endfunction

   task automatic open_xfer();
      step(0, 0); step(1, 0); step(1, 1); step(1, 0);
   endtask

   task automatic close_xfer();
      step(0, 0); step(1, 0); step(1, 1); step(1, 0); step(0, 0);
      repeat (4) @(posedge clk);
   endtask

   task automatic write(logic [31:0] seq, int n, string tag);
      open_xfer();
      for (int i = n - 1; i >= 0; i--) begin
         step(0, seq[i]);
         step(1, seq[i]);
      end
      close_xfer();
      exp_cfg = model(exp_cfg, seq, n);
      @(negedge clk);
      chk(tag, 32'(cfg), 32'(exp_cfg));
      chk({tag, " R6 oe after close"}, 32'(oe), 32'd1);
   endtask

   initial begin
      void'($urandom(32'h5EED1));
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      exp_cfg = 20'h02E78;
      @(negedge clk);
      chk("R1 reset value", 32'(cfg), 32'h02E78);
      chk("R1 oe idle", 32'(oe), 32'd1);

      // R2: idle clocking with data high opens nothing
      step(0, 1); step(1, 1);
      @(negedge clk); chk("R2 oe clk high", 32'(oe), 32'd0);
      step(0, 1);
      @(negedge clk); chk("R2 oe clk low", 32'(oe), 32'd1);
      chk("R2 cfg kept", 32'(cfg), 32'(exp_cfg));

      // R3: oe stays off inside a transfer with clock low
      open_xfer();
      step(0, 1);
      @(negedge clk); chk("R3 oe off in transfer", 32'(oe), 32'd0);
      step(1, 1); step(0, 0); step(1, 0);
      close_xfer();
      exp_cfg = model(exp_cfg, 32'b10, 2);
      @(negedge clk); chk("R4 two bits msb first", 32'(cfg), 32'(exp_cfg));

      write(32'b101, 3, "R5 three bits");
      write(32'hA5A5A, 20, "R4 R5 full word");
      write(32'h0, 0, "R7 empty write");
      write(32'h1FF0F0F, 24, "R8 over length");
      write(32'h1, 1, "R5 single bit");

      // R9: aborted opening sequence
      step(0, 0); step(1, 0); step(1, 1); step(0, 1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9 abort cfg kept", 32'(cfg), 32'(exp_cfg));
      chk("R9 abort oe back", 32'(oe), 32'd1);
      step(0, 0);

      for (int k = 0; k < 30; k++) begin
         int n;
         logic [31:0] seq;
         n = int'($urandom_range(0, 25));
         seq = $urandom;
         write(seq, n, "R5 R8 random write");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule